// File: doc/BRIEF.md
# Endian-Aware External Bus Sizer

This block sits between a 32-bit internal data port and a 16-bit external memory bus. Each internal access is a byte, a half-word or a word. The block turns it into one, two or four external bus cycles, depending on whether the addressed device is 8 or 16 bits wide. It drives the byte-lane strobes, the read and write strobes and the sub-cycle addresses. It also rebuilds read data into a single 32-bit value before it reports completion.

Byte order is chosen per memory area. An 8-bit control register holds one big-endian enable per group of areas. For big-endian areas, the block changes the order in which data parts appear on the bus and the lane an 8-bit device uses. The group that holds the boot areas is locked to little-endian. Misaligned half-word and word requests never reach the bus; they are answered with an address-error pulse.

Only one access is in flight at a time. The requester holds `req_valid` until it sees `req_done` or `req_aerr`.

Top module: `xbus_sizer`

## Requirements
- R1: The number of external cycles is set by size and device width: word/16-bit takes 2, half or byte/16-bit takes 1, word/8-bit takes 4, half/8-bit takes 2, byte/8-bit takes 1. Size code 0 is byte, 1 is half-word, 2 is word.
- R2: A half-word with address bit 0 set, or a word with address bits 1:0 not zero, gives a one-cycle `req_aerr` in the cycle after acceptance and starts no bus cycle. Byte accesses are accepted at any address.
- R3: Sub-cycle addresses start at the request address and rise by the device width (1 or 2) on each cycle. A cycle finishes only on a clock edge with `ext_rdy` high. The address stays stable while `ext_rdy` is low.
- R4: A byte access to a 16-bit device strobes only the high lane when address bit 0 XOR big-endian is 1, and only the low lane otherwise. Read data returns zero-extended in bits 7:0.
- R5: Every cycle to an 8-bit device strobes exactly one lane: the low lane (bits 7:0) for little-endian areas, the high lane (bits 15:8) for big-endian areas.
- R6: In little-endian order the lowest-addressed cycle carries the least significant part of the data. In big-endian order it carries the most significant part. A half-word on a 16-bit cycle always puts its upper byte on bus bits 15:8.
- R7: The control register resets to 0 (all little-endian), is written with `cfg_we` and reads on `cfg_rdata`. Bit b makes big-endian: b0 areas 4-5, b1 area 6, b2 areas 7-8, b3 areas 9-10, b4 areas 11-12, b5 areas 13-14, b6 areas 15-16, b7 areas 17-18.
- R8: Control bit 3 always reads 0 and ignores writes, so areas 9 and 10 stay little-endian.
- R9: Areas below 4 or above 18 are little-endian whatever the register holds.
- R10: `req_done` pulses for one cycle after the edge that completes the last sub-cycle, with the assembled read data on `req_rdata`. `req_done` and `req_aerr` are never high together.
- R11: `ext_rd` (read) or `ext_wr` (write) is high for the whole of every sub-cycle, never both, and both are low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the byte-order control register |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | Internal access request, held until done or error |
| req_addr | input | AW | Internal byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_area | input | 5 | Memory area number of the access |
| req_dev8 | input | 1 | Addressed device is 8 bits wide |
| req_done | output | 1 | One-cycle completion pulse |
| req_aerr | output | 1 | One-cycle address-error pulse |
| req_rdata | output | 32 | Assembled read data, valid with req_done |
| ext_addr | output | AW | External sub-cycle address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_bs_hi | output | 1 | High-lane (15:8) byte strobe |
| ext_bs_lo | output | 1 | Low-lane (7:0) byte strobe |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_rdy | input | 1 | Sub-cycle completes on this edge |

## Verification
The hardest case to reach is a big-endian word read from an 8-bit device with wait states between sub-cycles. Here the byte index runs downward while the address runs upward, and each partial result must survive several idle cycles. The bench's device model holds `ext_rdy` low for a set number of cycles per sub-cycle. It puts only the expected lane on the bus and fills the other lane with a marker byte. A wrong lane or a wrong ordering therefore shows up in the assembled value. It also tests the register lock by writing all ones and then accessing areas 9 and 10.

// File: rtl/xbs_pkg.sv
// Package: shared types for the external bus sizer.
// Assumes size codes 0/1/2 for byte/half/word; code 3 is treated as word.
package xbs_pkg;
    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2
    } xs_size_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } xs_state_t;
endpackage

// File: rtl/xbs_endian_reg.sv
// Byte-order control register and area lookup.
// Holds one big-endian enable per area group; the locked bit is forced to 0.
// Assumes area numbers outside FIRST_AREA..LAST_AREA map to little-endian.
module xbs_endian_reg #(
    parameter int CFG_W      = 8,
    parameter int AREA_W     = 5,
    parameter int LOCK_BIT   = 3,
    parameter int FIRST_AREA = 4,
    parameter int LAST_AREA  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [AREA_W-1:0] area,
    output logic              area_big
);
    localparam logic [CFG_W-1:0] LOCK_MASK = ~(CFG_W'(1) << LOCK_BIT);
    localparam int IDX_W = $clog2(CFG_W);

    logic [CFG_W-1:0] cfg_q;
    logic [AREA_W-1:0] rel;
    logic [IDX_W-1:0]  grp;
    logic              in_range;

    // Register write with the locked bit masked off.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata & LOCK_MASK;
    end

    assign cfg_rdata = cfg_q;

    // Area-to-group index: first two areas share group 0, the next is alone, then pairs.
    always_comb begin
        in_range = (area >= AREA_W'(FIRST_AREA)) && (area <= AREA_W'(LAST_AREA));
        rel      = area - AREA_W'(FIRST_AREA - 1);
        if (area <= AREA_W'(FIRST_AREA + 1)) grp = '0;
        else                                 grp = IDX_W'(rel >> 1);
        area_big = in_range && cfg_q[grp];
    end

    // R8: the locked bit never reads back as 1 after a write.
    assert_lock_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[LOCK_BIT] == 1'b0));
endmodule

// File: rtl/xbs_lane_map.sv
// Combinational sub-cycle planner.
// For the current beat it gives the beat count, lane strobes and which
// internal byte or half-word travels on the bus. Assumes aligned requests.
module xbs_lane_map (
    input  logic [1:0] size,
    input  logic       dev8,
    input  logic       big,
    input  logic       a0,
    input  logic [1:0] beat,
    output logic [1:0] last_beat,
    output logic       bs_hi,
    output logic       bs_lo,
    output logic       byte_xfer,
    output logic [1:0] byte_sel,
    output logic       half_sel
);
    import xbs_pkg::*;

    xs_size_t sz;
    assign sz = xs_size_t'(size);

    // Beat count, lanes and data part selection for one sub-cycle.
    always_comb begin
        last_beat = 2'd0;
        bs_hi     = 1'b1;
        bs_lo     = 1'b1;
        byte_xfer = 1'b0;
        byte_sel  = 2'd0;
        half_sel  = 1'b0;
        if (dev8) begin
            case (sz)
                XS_BYTE: last_beat = 2'd0;
                XS_HALF: last_beat = 2'd1;
                default: last_beat = 2'd3;
            endcase
            byte_xfer = 1'b1;
            bs_hi     = big;
            bs_lo     = !big;
            byte_sel  = big ? (last_beat - beat) : beat;
        end else begin
            case (sz)
                XS_BYTE: begin
                    byte_xfer = 1'b1;
                    bs_hi     = a0 ^ big;
                    bs_lo     = !(a0 ^ big);
                end
                XS_HALF: last_beat = 2'd0;
                default: begin
                    last_beat = 2'd1;
                    half_sel  = big ? !beat[0] : beat[0];
                end
            endcase
        end
    end
endmodule

// File: rtl/xbs_seq.sv
// Access sequencer: accepts one request, checks alignment, walks the sub-cycles
// on the external bus and assembles read data. Assumes the requester holds
// req_valid until done or error and keeps inputs stable meanwhile.
module xbs_seq #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    input  logic          req_dev8,
    input  logic          req_big,
    output logic          req_done,
    output logic          req_aerr,
    output logic [31:0]   req_rdata,
    output logic [AW-1:0] ext_addr,
    output logic [15:0]   ext_wdata,
    input  logic [15:0]   ext_rdata,
    output logic          ext_bs_hi,
    output logic          ext_bs_lo,
    output logic          ext_rd,
    output logic          ext_wr,
    input  logic          ext_rdy
);
    import xbs_pkg::*;

    xs_state_t     st_q;
    logic [AW-1:0] base_q;
    logic [1:0]    size_q;
    logic          write_q, dev8_q, big_q;
    logic [31:0]   wdata_q, rdata_q;
    logic [1:0]    beat_q;
    logic          done_q, aerr_q;

    logic          accept, misaligned, in_bus;
    logic [1:0]    last_beat, byte_sel;
    logic          bs_hi, bs_lo, byte_xfer, half_sel;
    logic [7:0]    lane_byte;

    xbs_lane_map u_map (
        .size      (size_q),
        .dev8      (dev8_q),
        .big       (big_q),
        .a0        (base_q[0]),
        .beat      (beat_q),
        .last_beat (last_beat),
        .bs_hi     (bs_hi),
        .bs_lo     (bs_lo),
        .byte_xfer (byte_xfer),
        .byte_sel  (byte_sel),
        .half_sel  (half_sel)
    );

    // Acceptance and alignment decode.
    always_comb begin
        in_bus = (st_q == ST_BUS);
        accept = req_valid && !in_bus && !done_q && !aerr_q;
        case (xs_size_t'(req_size))
            XS_BYTE: misaligned = 1'b0;
            XS_HALF: misaligned = req_addr[0];
            default: misaligned = (req_addr[1:0] != 2'b00);
        endcase
    end

    // Request capture, beat stepping and read assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            size_q  <= 2'd0;
            write_q <= 1'b0;
            dev8_q  <= 1'b0;
            big_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            beat_q  <= 2'd0;
            done_q  <= 1'b0;
            aerr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            aerr_q <= accept && misaligned;
            if (accept && !misaligned) begin
                st_q    <= ST_BUS;
                base_q  <= req_addr;
                size_q  <= req_size;
                write_q <= req_write;
                dev8_q  <= req_dev8;
                big_q   <= req_big;
                wdata_q <= req_wdata;
                rdata_q <= '0;
                beat_q  <= 2'd0;
            end else if (in_bus && ext_rdy) begin
                if (!write_q) begin
                    if (byte_xfer) rdata_q[8*byte_sel +: 8]  <= lane_byte;
                    else           rdata_q[16*half_sel +: 16] <= ext_rdata;
                end
                if (beat_q == last_beat) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    beat_q <= beat_q + 2'd1;
                end
            end
        end
    end

    // External drive for the current sub-cycle.
    always_comb begin
        lane_byte = bs_hi ? ext_rdata[15:8] : ext_rdata[7:0];
        ext_addr  = base_q + (dev8_q ? AW'(beat_q) : AW'({beat_q, 1'b0}));
        if (byte_xfer) ext_wdata = {2{wdata_q[8*byte_sel +: 8]}};
        else           ext_wdata = wdata_q[16*half_sel +: 16];
        ext_bs_hi = in_bus && bs_hi;
        ext_bs_lo = in_bus && bs_lo;
        ext_rd    = in_bus && !write_q;
        ext_wr    = in_bus && write_q;
    end

    assign req_done  = done_q;
    assign req_aerr  = aerr_q;
    assign req_rdata = rdata_q;

    // R2: an address error never coincides with bus activity.
    assert_no_bus_on_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_aerr |-> !(ext_rd || ext_wr));
    // R1: the beat counter stays within the planned count.
    assert_beat_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_bus |-> (beat_q <= last_beat));
    // R3: address holds while the device is not ready.
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_rd || ext_wr) && !ext_rdy) |=> $stable(ext_addr));
    // R5: 8-bit device cycles use exactly one lane.
    assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_rd || ext_wr) && dev8_q) |-> ($countones({ext_bs_hi, ext_bs_lo}) == 1));
    // R10: completion and error are exclusive.
    assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_done && req_aerr));
    // R11: read and write strobes are never both active.
    assert_rw_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_rd, ext_wr}));
endmodule

// File: rtl/xbus_sizer.sv
// Top: endian-aware external bus sizer.
// Looks up the area byte order, then hands the request to the sequencer.
// Assumes the device width is supplied with each request.
module xbus_sizer #(
    parameter int AW     = 24,
    parameter int CFG_W  = 8,
    parameter int AREA_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_dev8,
    output logic              req_done,
    output logic              req_aerr,
    output logic [31:0]       req_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata,
    output logic              ext_bs_hi,
    output logic              ext_bs_lo,
    output logic              ext_rd,
    output logic              ext_wr,
    input  logic              ext_rdy
);
    logic area_big;

    xbs_endian_reg #(.CFG_W(CFG_W), .AREA_W(AREA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .area      (req_area),
        .area_big  (area_big)
    );

    xbs_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_dev8  (req_dev8),
        .req_big   (area_big),
        .req_done  (req_done),
        .req_aerr  (req_aerr),
        .req_rdata (req_rdata),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_rdata (ext_rdata),
        .ext_bs_hi (ext_bs_hi),
        .ext_bs_lo (ext_bs_lo),
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .ext_rdy   (ext_rdy)
    );
endmodule

// File: tb/sim_xbus_sizer.sv
module sim_xbus_sizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  req_area = '0;
    logic        req_dev8 = 1'b0;
    logic        req_done, req_aerr;
    logic [31:0] req_rdata;
    logic [23:0] ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata = '0;
    logic        ext_bs_hi, ext_bs_lo, ext_rd, ext_wr;
    logic        ext_rdy = 1'b0;

    int tests = 0, fails = 0, cyc = 0;

    // device model state
    logic [15:0] mem16 [0:127];
    logic [7:0]  mem8  [0:255];
    logic        dev_big = 1'b0;
    int          wait_n = 0, wcnt = 0;
    int          nbeat = 0;
    logic [23:0] log_addr [0:7];
    logic        log_hi   [0:7];
    logic        log_lo   [0:7];
    logic [31:0] rd_val;
    logic        saw_err;
    int          lat;

    xbus_sizer u0 (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Device: answers after wait_n idle cycles, drives only the expected lane for 8-bit devices.
    always @(negedge clk) begin
        if (ext_rd || ext_wr) begin
            if (ext_rdy) wcnt = 0;
            if (wcnt >= wait_n) begin
                ext_rdy = 1'b1;
                if (nbeat < 8) begin
                    log_addr[nbeat] = ext_addr;
                    log_hi[nbeat]   = ext_bs_hi;
                    log_lo[nbeat]   = ext_bs_lo;
                end
                nbeat = nbeat + 1;
                if (req_dev8) begin
                    if (ext_wr) mem8[ext_addr[7:0]] = dev_big ? ext_wdata[15:8] : ext_wdata[7:0];
                    ext_rdata = dev_big ? {mem8[ext_addr[7:0]], 8'hEE} : {8'hEE, mem8[ext_addr[7:0]]};
                end else begin
                    if (ext_wr && ext_bs_hi) mem16[ext_addr[7:1]][15:8] = ext_wdata[15:8];
                    if (ext_wr && ext_bs_lo) mem16[ext_addr[7:1]][7:0]  = ext_wdata[7:0];
                    ext_rdata = mem16[ext_addr[7:1]];
                end
            end else begin
                ext_rdy = 1'b0;
                wcnt = wcnt + 1;
            end
        end else begin
            ext_rdy = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [4:0] area, input logic [23:0] a, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd, input logic d8, input logic big);
        @(negedge clk);
        nbeat = 0; dev_big = big; saw_err = 1'b0; lat = 0;
        req_valid = 1'b1; req_area = area; req_addr = a; req_size = sz;
        req_write = wr; req_wdata = wd; req_dev8 = d8;
        do begin
            @(negedge clk);
            lat = lat + 1;
        end while (!req_done && !req_aerr && lat < 1000);
        saw_err = req_aerr;
        rd_val = req_rdata;
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 8'h00, "R7 reset cfg", 32'(cfg_rdata), 0);
        chk(!ext_rd && !ext_wr, "R11 idle strobes", {30'd0, ext_rd, ext_wr}, 0);
        chk(!req_done && !req_aerr, "R10 idle done/err", {30'd0, req_done, req_aerr}, 0);
    endtask

    task automatic t_cfg;
        cfg_write(8'hFF);
        chk(cfg_rdata == 8'hF7, "R8 lock bit read", 32'(cfg_rdata), 32'hF7);
        cfg_write(8'h08);
        chk(cfg_rdata == 8'h00, "R8 lock write ignored", 32'(cfg_rdata), 0);
    endtask

    task automatic t_word16;
        cfg_write(8'h10); // b4: areas 11-12 big
        access(5'd4, 24'h20, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b0);
        chk(nbeat == 2, "R1 word/16 beats", nbeat, 2);
        chk(log_addr[0] == 24'h20 && log_addr[1] == 24'h22, "R3 word/16 addrs", {log_addr[0][15:0], log_addr[1][15:0]}, 32'h00200022);
        chk(mem16[8'h10] == 16'h3344 && mem16[8'h11] == 16'h1122, "R6 LE word/16 order", {mem16[8'h10], mem16[8'h11]}, 32'h33441122);
        access(5'd4, 24'h20, 2'd2, 1'b0, 0, 1'b0, 1'b0);
        chk(rd_val == 32'h11223344, "R10 LE word/16 read", rd_val, 32'h11223344);
        access(5'd12, 24'h40, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b1);
        chk(mem16[8'h20] == 16'h1122 && mem16[8'h21] == 16'h3344, "R6 BE word/16 order", {mem16[8'h20], mem16[8'h21]}, 32'h11223344);
        access(5'd12, 24'h40, 2'd2, 1'b0, 0, 1'b0, 1'b1);
        chk(rd_val == 32'h11223344, "R6 BE word/16 read", rd_val, 32'h11223344);
    endtask

    task automatic t_word8;
        cfg_write(8'h80); // b7: areas 17-18 big
        access(5'd6, 24'h60, 2'd2, 1'b1, 32'h11223344, 1'b1, 1'b0);
        chk(nbeat == 4, "R1 word/8 beats", nbeat, 4);
        chk(log_addr[3] == 24'h63, "R3 word/8 last addr", 32'(log_addr[3]), 32'h63);
        chk(log_lo[0] && !log_hi[0] && log_lo[3] && !log_hi[3], "R5 LE 8-bit low lane", {log_hi[0], log_lo[0]}, 1);
        chk({mem8[8'h60], mem8[8'h61], mem8[8'h62], mem8[8'h63]} == 32'h44332211, "R6 LE word/8 order",
            {mem8[8'h60], mem8[8'h61], mem8[8'h62], mem8[8'h63]}, 32'h44332211);
        access(5'd17, 24'h70, 2'd2, 1'b1, 32'h11223344, 1'b1, 1'b1);
        chk(log_hi[1] && !log_lo[1], "R5 BE 8-bit high lane", {log_hi[1], log_lo[1]}, 2);
        chk({mem8[8'h70], mem8[8'h71], mem8[8'h72], mem8[8'h73]} == 32'h11223344, "R6 BE word/8 order",
            {mem8[8'h70], mem8[8'h71], mem8[8'h72], mem8[8'h73]}, 32'h11223344);
        access(5'd18, 24'h72, 2'd1, 1'b0, 0, 1'b1, 1'b1);
        chk(nbeat == 2, "R1 half/8 beats", nbeat, 2);
        chk(rd_val == 32'h00003344, "R6 BE half/8 read", rd_val, 32'h3344);
        access(5'd6, 24'h61, 2'd0, 1'b0, 0, 1'b1, 1'b0);
        chk(nbeat == 1 && rd_val == 32'h33, "R1 byte/8 read", rd_val, 32'h33);
    endtask

    task automatic t_small16;
        cfg_write(8'h10);
        mem16[8'h18] = 16'h0000;
        access(5'd4, 24'h31, 2'd0, 1'b1, 32'h000000A5, 1'b0, 1'b0);
        chk(nbeat == 1 && log_hi[0] && !log_lo[0], "R4 LE odd byte high lane", {log_hi[0], log_lo[0]}, 2);
        chk(mem16[8'h18] == 16'hA500, "R4 LE odd byte lane data", 32'(mem16[8'h18]), 32'hA500);
        access(5'd11, 24'h31, 2'd0, 1'b1, 32'h0000005A, 1'b0, 1'b1);
        chk(!log_hi[0] && log_lo[0], "R4 BE odd byte low lane", {log_hi[0], log_lo[0]}, 1);
        access(5'd11, 24'h31, 2'd0, 1'b0, 0, 1'b0, 1'b1);
        chk(rd_val == 32'h0000005A, "R4 BE byte read zero-ext", rd_val, 32'h5A);
        access(5'd12, 24'h34, 2'd1, 1'b1, 32'hFFFFBEEF, 1'b0, 1'b1);
        chk(nbeat == 1 && mem16[8'h1A] == 16'hBEEF, "R6 BE half/16 bus order", 32'(mem16[8'h1A]), 32'hBEEF);
    endtask

    task automatic t_align;
        access(5'd4, 24'h51, 2'd1, 1'b1, 32'h1, 1'b0, 1'b0);
        chk(saw_err && nbeat == 0 && lat == 1, "R2 odd half error", {saw_err, 7'd0, 8'(nbeat), 16'(lat)}, 32'h80000001);
        access(5'd4, 24'h52, 2'd2, 1'b0, 0, 1'b1, 1'b0);
        chk(saw_err && nbeat == 0, "R2 word addr 2 error", 32'(nbeat), 0);
        access(5'd4, 24'h53, 2'd0, 1'b0, 0, 1'b1, 1'b0);
        chk(!saw_err && nbeat == 1, "R2 odd byte accepted", 32'(saw_err), 0);
    endtask

    task automatic t_areas;
        cfg_write(8'hFF);
        access(5'd2, 24'h80, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 1'b0);
        chk(mem8[8'h80] == 8'hD4 && log_lo[0], "R9 area 2 little", 32'(mem8[8'h80]), 32'hD4);
        access(5'd20, 24'h84, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 1'b0);
        chk(mem8[8'h84] == 8'hD4 && log_lo[0], "R9 area 20 little", 32'(mem8[8'h84]), 32'hD4);
        access(5'd10, 24'h88, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 1'b0);
        chk(mem8[8'h88] == 8'hD4 && log_lo[0], "R8 area 10 stays little", 32'(mem8[8'h88]), 32'hD4);
        access(5'd5, 24'h8C, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 1'b1);
        chk(mem8[8'h8C] == 8'hA1 && log_hi[0], "R7 area 5 big via b0", 32'(mem8[8'h8C]), 32'hA1);
        cfg_write(8'h00);
    endtask

    task automatic t_wait;
        cfg_write(8'h80);
        wait_n = 3;
        access(5'd17, 24'h90, 2'd2, 1'b1, 32'hCAFE1234, 1'b1, 1'b1);
        access(5'd17, 24'h90, 2'd2, 1'b0, 0, 1'b1, 1'b1);
        chk(rd_val == 32'hCAFE1234, "R3 BE word/8 with waits", rd_val, 32'hCAFE1234);
        chk(lat >= 16, "R3 each beat waits for ready", 32'(lat), 16);
        wait_n = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem16[i] = 16'h0;
        for (int i = 0; i < 256; i++) mem8[i] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_word16;
        t_word8;
        t_small16;
        t_align;
        t_areas;
        t_wait;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule